// File: doc/BRIEF.md
# Wake-Context Reset Domain Generator

This block turns two active-low reset inputs, a chip-wide power-on reset and a bus reset, into three clear signals. Each clear serves one class of register bits. Ordinary bits clear on either reset. Global-only bits clear only on the chip-wide reset. Wake-context bits normally clear on either reset. When the wake-event enable is armed, they survive a bus reset, so that wake state outlives the reset that comes with a power-state change. A suspend input masks the chip-wide reset, which preserves every register while it is high.

Both reset inputs take effect at once, without waiting for a clock edge. They are released in step with the clock after a short synchronizer chain. The wake-event enable is held in a register of its own that belongs to the global-only class, so a bus reset can never disarm the protection it provides.

A small register bank holds one example register per class plus the enable bit. This lets the clearing rules be observed at the ports. Software-style writes use an address and data. The register contents are always visible on the outputs.

Top module: `wake_rst_domains`

## Requirements
- R1: The ordinary register (write address 0) reads zero after any bus reset, and after any chip-wide reset that is not masked by suspend. `clr_ordinary` is high while either reset is in effect.
- R2: With the wake enable (address 3, data bit 0) set to 1, a bus reset leaves the wake-context register (address 1) unchanged.
- R3: With the wake enable at 0, a bus reset clears the wake-context register. `clr_wake` follows `clr_ordinary` in that case.
- R4: A bus reset never changes the global-only register (address 2) or the wake enable, whatever the enable's value. `clr_global` stays low during a bus reset alone.
- R5: While `suspend` is high, a chip-wide reset has no effect: all four stored values are preserved and `clr_global` stays low.
- R6: A reset input that goes low raises the matching clear outputs before the next rising clock edge.
- R7: After the reset inputs return high, the clear outputs stay high across exactly two rising edges (SYNC_STAGES = 2) and are low after the second.
- R8: When a register's clear is active, a write to that register in the same cycle is lost, and the register reads zero.
- R9: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_addr` (0 ordinary, 1 wake-context, 2 global-only, 3 enable in bit 0). The stored value appears on the outputs after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| glob_rst_n | input | 1 | Chip-wide reset, active low |
| bus_rst_n | input | 1 | Bus reset, active low |
| suspend | input | 1 | High masks the chip-wide reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | DATA_W | Write data |
| clr_ordinary | output | 1 | Clear for ordinary bits, active high |
| clr_wake | output | 1 | Clear for wake-context bits, active high |
| clr_global | output | 1 | Clear for global-only bits, active high |
| ord_q | output | DATA_W | Ordinary example register |
| wake_q | output | DATA_W | Wake-context example register |
| glob_q | output | DATA_W | Global-only example register |
| wake_en_q | output | 1 | Wake-event enable |

## Verification
The clear outputs rise with no clock involved. The bench therefore samples them 1 ns after it drives a reset low, which is ahead of the next rising edge. On release, the clears stay high through the first rising edge and fall on the second. The bench checks them at the falling edge after each of those two edges. A register clears or loads on the first rising edge after its clear or its write. All register checks come at falling edges, after the release has fully completed. The sweep covers every mix of reset source, suspend and enable value, and it computes each expected register value from the requirements.

// File: rtl/wrd_pkg.sv
// Shared constants for the reset domain generator.
// Assumes a two-bit write address space of four registers.
package wrd_pkg;
    localparam int unsigned ADDR_W      = 2;
    localparam int unsigned NUM_DOMAINS = 3;

    // Domain index, also the write address of its example register.
    typedef enum logic [ADDR_W-1:0] {
        DOM_ORD  = 2'd0,
        DOM_WAKE = 2'd1,
        DOM_GLOB = 2'd2,
        DOM_CTRL = 2'd3
    } dom_addr_t;

    typedef struct packed {
        logic glob;
        logic wake;
        logic ord;
    } clr_vec_t;
endpackage

// File: rtl/wrd_rst_sync.sv
// Reset synchronizer: takes effect at once on a low input, releases after
// STAGES rising edges. Assumes STAGES >= 2.
module wrd_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic rst_out_n
);
    logic [STAGES-1:0] chain;

    // Shift ones in after release; clear the whole chain on assertion.
    always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n) chain <= '0;
        else           chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_out_n = chain[STAGES-1];
endmodule

// File: rtl/wrd_domain_map.sv
// Maps the synchronized reset levels and the wake enable onto the three
// per-domain clears. Purely combinational.
module wrd_domain_map
    import wrd_pkg::*;
(
    input  logic     glob_act,
    input  logic     bus_act,
    input  logic     wake_en,
    output clr_vec_t clr
);
    // Wake context is spared by the bus reset only while armed.
    always_comb begin
        clr.glob = glob_act;
        clr.ord  = glob_act | bus_act;
        clr.wake = glob_act | (bus_act & ~wake_en);
    end
endmodule

// File: rtl/wrd_reg_bank.sv
// Example register bank: one register per domain plus the wake enable,
// which lives in the global-only domain. Clears win over writes.
module wrd_reg_bank
    import wrd_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  clr_vec_t          clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ord_q,
    output logic [DATA_W-1:0] wake_q,
    output logic [DATA_W-1:0] glob_q,
    output logic              wake_en_q
);
    logic [NUM_DOMAINS-1:0] clr_bits;
    logic [DATA_W-1:0]      regs [NUM_DOMAINS];

    assign clr_bits = {clr.glob, clr.wake, clr.ord};

    for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
        // Domain register: synchronous clear, else load on a matching write.
        always_ff @(posedge clk) begin
            if (clr_bits[d])
                regs[d] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(d))
                regs[d] <= wr_data;
        end
    end

    // Wake enable: global-only, so a bus reset cannot disarm it.
    always_ff @(posedge clk) begin
        if (clr.glob)
            wake_en_q <= 1'b0;
        else if (wr_en && wr_addr == DOM_CTRL)
            wake_en_q <= wr_data[0];
    end

    assign ord_q  = regs[DOM_ORD];
    assign wake_q = regs[DOM_WAKE];
    assign glob_q = regs[DOM_GLOB];
endmodule

// File: rtl/wake_rst_domains.sv
// Top: gates the chip-wide reset with suspend, synchronizes both resets,
// derives the domain clears and holds the example registers.
// Assumes both reset inputs are active low and SYNC_STAGES >= 2.
module wake_rst_domains
    import wrd_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              glob_rst_n,
    input  logic              bus_rst_n,
    input  logic              suspend,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              clr_ordinary,
    output logic              clr_wake,
    output logic              clr_global,
    output logic [DATA_W-1:0] ord_q,
    output logic [DATA_W-1:0] wake_q,
    output logic [DATA_W-1:0] glob_q,
    output logic              wake_en_q
);
    logic     glob_gated_n;
    logic     glob_sync_n;
    logic     bus_sync_n;
    clr_vec_t clr;

    // Suspend holds the chip-wide reset inactive.
    assign glob_gated_n = glob_rst_n | suspend;

    wrd_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_glob (
        .clk       (clk),
        .rst_in_n  (glob_gated_n),
        .rst_out_n (glob_sync_n)
    );

    wrd_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_bus (
        .clk       (clk),
        .rst_in_n  (bus_rst_n),
        .rst_out_n (bus_sync_n)
    );

    wrd_domain_map u_map (
        .glob_act (~glob_sync_n),
        .bus_act  (~bus_sync_n),
        .wake_en  (wake_en_q),
        .clr      (clr)
    );

    wrd_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ord_q     (ord_q),
        .wake_q    (wake_q),
        .glob_q    (glob_q),
        .wake_en_q (wake_en_q)
    );

    assign clr_ordinary = clr.ord;
    assign clr_wake     = clr.wake;
    assign clr_global   = clr.glob;
endmodule

// File: rtl/wrd_checker.sv
// Port-level properties of the reset domain generator. Checks are held off
// for the first few cycles, until the registers have been cleared once.
module wrd_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              suspend,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic              clr_ordinary,
    input logic              clr_wake,
    input logic              clr_global,
    input logic [DATA_W-1:0] ord_q,
    input logic [DATA_W-1:0] wake_q,
    input logic [DATA_W-1:0] glob_q,
    input logic              wake_en_q
);
    logic [2:0] age = 3'd0;
    logic       live;
    logic [1:0] susp_hist = 2'b00;

    // Count early cycles so properties start from a defined state.
    always_ff @(posedge clk) if (age != 3'd7) age <= age + 3'd1;
    // Remember recent suspend levels.
    always_ff @(posedge clk) susp_hist <= {susp_hist[0], suspend};

    assign live = (age == 3'd7);

    assert_ord_cleared_R1: assert property (@(posedge clk) disable iff (!live)
        clr_ordinary |=> ord_q == '0);

    assert_wake_kept_R2: assert property (@(posedge clk) disable iff (!live)
        (wake_en_q && !clr_global && !(wr_en && wr_addr == 2'd1)) |=> $stable(wake_q));

    assert_wake_follows_R3: assert property (@(posedge clk) disable iff (!live)
        (!wake_en_q && clr_ordinary) |-> clr_wake);

    assert_glob_kept_R4: assert property (@(posedge clk) disable iff (!live)
        (!clr_global && !(wr_en && wr_addr == 2'd2)) |=> $stable(glob_q));

    assert_enable_kept_R4: assert property (@(posedge clk) disable iff (!live)
        (!clr_global && !(wr_en && wr_addr == 2'd3)) |=> $stable(wake_en_q));

    assert_suspend_masks_R5: assert property (@(posedge clk) disable iff (!live)
        (suspend && susp_hist == 2'b11) |-> !clr_global);
endmodule

bind wake_rst_domains wrd_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .suspend      (suspend),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .clr_ordinary (clr_ordinary),
    .clr_wake     (clr_wake),
    .clr_global   (clr_global),
    .ord_q        (ord_q),
    .wake_q       (wake_q),
    .glob_q       (glob_q),
    .wake_en_q    (wake_en_q)
);

// File: tb/wake_rst_domains_test.sv
module wake_rst_domains_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          glob_rst_n = 1'b0;
    logic          bus_rst_n  = 1'b0;
    logic          suspend = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          clr_ordinary, clr_wake, clr_global;
    logic [DW-1:0] ord_q, wake_q, glob_q;
    logic          wake_en_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wake_rst_domains #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
        .clk(clk), .glob_rst_n(glob_rst_n), .bus_rst_n(bus_rst_n),
        .suspend(suspend), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_ordinary(clr_ordinary), .clr_wake(clr_wake), .clr_global(clr_global),
        .ord_q(ord_q), .wake_q(wake_q), .glob_q(glob_q), .wake_en_q(wake_en_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_clears(input string req, input logic eo, input logic ew, input logic eg);
        check({req, " clr_ordinary"}, {31'd0, clr_ordinary}, {31'd0, eo});
        check({req, " clr_wake"},     {31'd0, clr_wake},     {31'd0, ew});
        check({req, " clr_global"},   {31'd0, clr_global},   {31'd0, eg});
    endtask

    // One scenario: preload, apply reset(s) with given suspend and enable, verify.
    task automatic scenario(input logic dg, input logic db, input logic susp,
                            input logic en, input logic [DW-1:0] pat);
        logic geff, e_ord, e_wake, e_glob;
        geff   = dg & ~susp;
        e_ord  = geff | db;
        e_wake = geff | (db & ~en);
        e_glob = geff;
        write_reg(2'd0, pat);
        write_reg(2'd1, pat ^ 8'h3C);
        write_reg(2'd2, pat ^ 8'hC3);
        write_reg(2'd3, {7'd0, en});
        check("R9 write ord", {24'd0, ord_q}, {24'd0, pat});
        check("R9 write en", {31'd0, wake_en_q}, {31'd0, en});
        @(negedge clk);
        suspend = susp;
        @(negedge clk);
        glob_rst_n = ~dg;
        bus_rst_n  = ~db;
        #1;
        check_clears("R6 immediate", e_ord, e_wake, e_glob);
        if (db && !geff) check("R4 no global clear on bus reset", {31'd0, clr_global}, 32'd0);
        if (dg && susp)  check("R5 suspend masks clear", {31'd0, clr_global}, 32'd0);
        repeat (3) @(negedge clk);
        glob_rst_n = 1'b1;
        bus_rst_n  = 1'b1;
        @(negedge clk);
        check_clears("R7 held one edge", e_ord, e_wake, e_glob);
        @(negedge clk);
        check_clears("R7 released", 1'b0, 1'b0, 1'b0);
        check("R1 ord", {24'd0, ord_q}, e_ord ? 32'd0 : {24'd0, pat});
        check(en ? "R2 wake" : "R3 wake", {24'd0, wake_q},
              e_wake ? 32'd0 : {24'd0, pat ^ 8'h3C});
        check(susp ? "R5 glob" : "R4 glob", {24'd0, glob_q},
              e_glob ? 32'd0 : {24'd0, pat ^ 8'hC3});
        check("R4 enable", {31'd0, wake_en_q}, {31'd0, en & ~e_glob});
        suspend = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // Reset state after the initial assertion of both resets.
        repeat (4) @(negedge clk);
        glob_rst_n = 1'b1;
        bus_rst_n  = 1'b1;
        repeat (3) @(negedge clk);
        check_clears("R7 reset state", 1'b0, 1'b0, 1'b0);
        check("R1 reset ord", {24'd0, ord_q}, 32'd0);
        check("R3 reset wake", {24'd0, wake_q}, 32'd0);
        check("R4 reset glob", {24'd0, glob_q}, 32'd0);
        check("R4 reset enable", {31'd0, wake_en_q}, 32'd0);

        // Sweep reset source, suspend and enable.
        for (int i = 0; i < 24; i++) begin
            logic dg, db, s, e;
            int src;
            src = i % 3;
            dg  = (src != 1);
            db  = (src != 0);
            s   = ((i / 3) % 2) == 1;
            e   = ((i / 6) % 2) == 1;
            scenario(dg, db, s, e, 8'hA5 ^ 8'(i * 7));
        end

        // R8: write to a register whose clear is active is lost.
        write_reg(2'd3, 8'h00);
        @(negedge clk);
        bus_rst_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 ord write lost", {24'd0, ord_q}, 32'd0);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h66;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 wake write lost", {24'd0, wake_q}, 32'd0);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 glob write during bus reset", {24'd0, glob_q}, 32'h77);
        bus_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 ord after release", {24'd0, ord_q}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule